// File: doc/BRIEF.md
# Staged Per-Core Watchdog Array

This block holds one hardware watchdog per processor core. Each watchdog has a down-counter that software reloads through a configuration word and keeps alive with a per-core poke strobe. A prescaler divides the clock, and the counter decrements once per prescaler interval. The 16-bit length in the configuration word loads the upper bits of a wider counter, and the low fraction bits load as zero. When the counter runs out without a poke, the watchdog moves up one escalation stage and reloads for another full period. The first expiry raises an interrupt. The second raises a non-maskable interrupt. The third requests a chip-wide soft reset.

A 2-bit mode limits how far escalation may go. Mode 0 is off, mode 1 stops at the interrupt, mode 2 stops at the non-maskable interrupt, and mode 3 goes through to the soft reset. After the last stage that the mode allows, the counter stops. Software can select any core and read back its current count to see how much time is left before the next stage. Writing an all-zero configuration word turns off that core's watchdog.

Top module: `wdog_array`

## Requirements
- R1: After reset every core is off: the interrupt, non-maskable interrupt and soft-reset outputs are low, and every core reads back a count of 0.
- R2: A configuration write to core k stores the length and mode and sets the count of core k to length shifted left by FRAC_W, with zeros in the low FRAC_W bits. The count is visible on the read port in the cycle after the write. Bits 1:0 of the mode are 0 = off, 1 = interrupt, 2 = interrupt then non-maskable interrupt, 3 = all three stages.
- R3: While the counter runs, it decrements by one once every PRESCALE clock cycles. The prescaler restarts from zero on every poke and on every configuration write, so the first decrement comes a full PRESCALE cycles after the reload.
- R4: With reload value L, an unpoked period lasts (L+1)*PRESCALE cycles. The expiry that ends the first period raises the interrupt output and reloads the counter.
- R5: Stages go in a fixed order, one full period each: interrupt, then non-maskable interrupt, then soft reset. The interrupt and non-maskable interrupt are levels that stay high until a poke or a configuration write.
- R6: The soft-reset request is a pulse one cycle long, issued at the third expiry in mode 3.
- R7: Stages beyond the mode never assert. After the last enabled stage the counter holds at its reload value.
- R8: A poke clears the stage outputs and reloads the counter from the stored length in the next cycle.
- R9: An all-zero configuration word drops all outputs of that core in the next cycle. Afterwards the count stays 0, and pokes cause no escalation.
- R10: Each poke bit and each configuration write affects only the addressed core.
- R11: If a configuration write and a poke reach the same core in the same cycle, the new length is used for the reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_core_i | input | CORE_W | Core addressed by the configuration write |
| cfg_len_i | input | LEN_W | Reload length, upper counter bits |
| cfg_mode_i | input | 2 | Escalation mode |
| poke_i | input | NUM_CORES | Per-core keep-alive strobe |
| rd_core_i | input | CORE_W | Core whose count is read back |
| rd_cnt_o | output | LEN_W+FRAC_W | Current count of the selected core |
| irq_o | output | NUM_CORES | Interrupt stage level per core |
| nmi_o | output | NUM_CORES | Non-maskable interrupt stage level per core |
| srst_o | output | NUM_CORES | Soft-reset request pulse per core |

## Verification
The bench builds the block with NUM_CORES=3, LEN_W=4, FRAC_W=2 and PRESCALE=2. With these values a period lasts from 10 to 26 cycles, so a full three-stage escalation, the stop after the last stage and the one-cycle soft-reset pulse can all be checked exactly at every cycle. Three cores give a count that is not a power of two. This exercises the address decode, and it lets the bench show that pokes to one core leave a running neighbour alone. PRESCALE=2 is the smallest interval in which a missing prescaler clear on a poke shows up as an early decrement.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    STG_ARMED = 2'd0,
    STG_IRQ   = 2'd1,
    STG_NMI   = 2'd2,
    STG_RST   = 2'd3
  } stage_e;

  localparam logic [1:0] MODE_OFF = 2'd0;
  localparam logic [1:0] MODE_IRQ = 2'd1;
  localparam logic [1:0] MODE_NMI = 2'd2;
  localparam logic [1:0] MODE_ALL = 2'd3;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRESCALE = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);
  localparam bit POW2 = ((PRESCALE & (PRESCALE - 1)) == 0);

  logic [PRE_W-1:0] pre_q;

  generate
    if (POW2) begin : g_wrap
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      pre_q <= '0;
        else if (clear_i) pre_q <= '0;
        else if (run_i)   pre_q <= pre_q + PRE_W'(1);
      end
    end else begin : g_cmp
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      pre_q <= '0;
        else if (clear_i) pre_q <= '0;
        else if (run_i)   pre_q <= (pre_q == LAST) ? '0 : pre_q + PRE_W'(1);
      end
    end
  endgenerate

  assign tick_o = run_i && !clear_i && (pre_q == LAST);

  // R3: ticks are at least one interval apart
  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int FRAC_W   = 8,
  parameter int PRESCALE = 256,
  localparam int CNT_W   = LEN_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic             poke_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             srst_o
);
  logic [LEN_W-1:0] len_q;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] cnt_q;
  stage_e           stage_q;
  logic             srst_q;

  logic [1:0]       stage_lvl;
  logic [CNT_W-1:0] reload_val;
  logic             load, run, tick, expire;

  assign stage_lvl  = stage_q;
  assign reload_val = {len_q, {FRAC_W{1'b0}}};
  assign load       = cfg_we_i | poke_i;
  assign run        = (mode_q != MODE_OFF) && (stage_lvl < mode_q);
  assign expire     = tick && (cnt_q == '0);

  wdog_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load),
    .run_i   (run),
    .tick_o  (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= '0;
      mode_q  <= MODE_OFF;
      cnt_q   <= '0;
      stage_q <= STG_ARMED;
      srst_q  <= 1'b0;
    end else if (cfg_we_i) begin
      // config wins over a simultaneous poke
      len_q   <= cfg_len_i;
      mode_q  <= cfg_mode_i;
      cnt_q   <= {cfg_len_i, {FRAC_W{1'b0}}};
      stage_q <= STG_ARMED;
      srst_q  <= 1'b0;
    end else if (poke_i) begin
      cnt_q   <= reload_val;
      stage_q <= STG_ARMED;
      srst_q  <= 1'b0;
    end else begin
      srst_q <= 1'b0;
      if (expire) begin
        cnt_q   <= reload_val;
        stage_q <= stage_e'(stage_lvl + 2'd1);
        srst_q  <= (stage_q == STG_NMI);
      end else if (tick) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign irq_o  = (stage_q != STG_ARMED);
  assign nmi_o  = (stage_q == STG_NMI) || (stage_q == STG_RST);
  assign srst_o = srst_q;

  a_r2_cfg_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cnt_o == {$past(cfg_len_i), {FRAC_W{1'b0}}}) && !irq_o);

  a_r3_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && !tick) |=> $stable(cnt_q));

  a_r5_nmi_needs_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> irq_o);

  a_r6_srst_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> !srst_o);

  a_r7_stop_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q != MODE_OFF) && (stage_lvl == mode_q) && !load) |=> ($stable(cnt_q) && $stable(stage_q)));

  a_r8_poke_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poke_i && !cfg_we_i) |=> (!irq_o && !nmi_o && (cnt_o == $past(reload_val))));

  a_r9_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_OFF) |-> (!irq_o && !nmi_o && !srst_o));
endmodule

// File: rtl/wdog_array.sv
module wdog_array
  import wdog_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int LEN_W     = 16,
  parameter int FRAC_W    = 8,
  parameter int PRESCALE  = 256,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int CNT_W    = LEN_W + FRAC_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CORE_W-1:0]    cfg_core_i,
  input  logic [LEN_W-1:0]     cfg_len_i,
  input  logic [1:0]           cfg_mode_i,
  input  logic [NUM_CORES-1:0] poke_i,
  input  logic [CORE_W-1:0]    rd_core_i,
  output logic [CNT_W-1:0]     rd_cnt_o,
  output logic [NUM_CORES-1:0] irq_o,
  output logic [NUM_CORES-1:0] nmi_o,
  output logic [NUM_CORES-1:0] srst_o
);
  logic [CNT_W-1:0]     cnt_all [NUM_CORES];
  logic [NUM_CORES-1:0] cfg_hit;

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    assign cfg_hit[k] = cfg_we_i && (cfg_core_i == CORE_W'(k));

    wdog_core #(
      .LEN_W    (LEN_W),
      .FRAC_W   (FRAC_W),
      .PRESCALE (PRESCALE)
    ) u_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_hit[k]),
      .cfg_len_i  (cfg_len_i),
      .cfg_mode_i (cfg_mode_i),
      .poke_i     (poke_i[k]),
      .cnt_o      (cnt_all[k]),
      .irq_o      (irq_o[k]),
      .nmi_o      (nmi_o[k]),
      .srst_o     (srst_o[k])
    );
  end

  always_comb begin
    rd_cnt_o = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (rd_core_i == CORE_W'(k)) rd_cnt_o = cnt_all[k];
    end
  end
endmodule

// File: tb/wdog_array_tb.sv
`timescale 1ns/1ps
module wdog_array_tb;
  localparam int NC = 3;
  localparam int LW = 4;
  localparam int FW = 2;
  localparam int PS = 2;
  localparam int CW = 2;
  localparam int NV = 15;

  // {core[15:14], len[13:10], mode[9:8], wait[7:0]}
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 4'd1, 2'd3, 8'd0},  {2'd0, 4'd1, 2'd3, 8'd5},
    {2'd0, 4'd1, 2'd3, 8'd9},  {2'd0, 4'd1, 2'd3, 8'd10},
    {2'd0, 4'd1, 2'd3, 8'd19}, {2'd0, 4'd1, 2'd3, 8'd20},
    {2'd0, 4'd1, 2'd3, 8'd29}, {2'd0, 4'd1, 2'd3, 8'd30},
    {2'd0, 4'd1, 2'd3, 8'd31}, {2'd1, 4'd2, 2'd1, 8'd18},
    {2'd1, 4'd2, 2'd1, 8'd40}, {2'd2, 4'd1, 2'd2, 8'd20},
    {2'd2, 4'd1, 2'd2, 8'd45}, {2'd1, 4'd2, 2'd0, 8'd50},
    {2'd2, 4'd3, 2'd3, 8'd39}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_core = '0;
  logic [LW-1:0] cfg_len = '0;
  logic [1:0]    cfg_mode = '0;
  logic [NC-1:0] poke = '0;
  logic [CW-1:0] rd_core = '0;
  logic [LW+FW-1:0] rd_cnt;
  logic [NC-1:0] irq, nmi, srst;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  wdog_array #(.NUM_CORES(NC), .LEN_W(LW), .FRAC_W(FW), .PRESCALE(PS)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .cfg_we_i (cfg_we), .cfg_core_i (cfg_core),
    .cfg_len_i (cfg_len), .cfg_mode_i (cfg_mode), .poke_i (poke),
    .rd_core_i (rd_core), .rd_cnt_o (rd_cnt), .irq_o (irq), .nmi_o (nmi), .srst_o (srst)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(int c, int len, int mode);
    cfg_we = 1'b1; cfg_core = CW'(c); cfg_len = LW'(len); cfg_mode = 2'(mode);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_poke(int c);
    poke = NC'(1) << c;
    @(negedge clk);
    poke = '0;
  endtask

  task automatic clear_all();
    for (int k = 0; k < NC; k++) write_cfg(k, 0, 0);
  endtask

  // expected {irq, nmi, srst, count} w cycles after a poke
  function automatic logic [8:0] model(int len, int mode, int w);
    int l = len << FW;
    int t = (l + 1) * PS;
    int st = w / t;
    int cnt;
    logic sr = 1'b0;
    if (mode == 0) begin
      st = 0; cnt = l;
    end else if (st >= mode) begin
      st = mode; cnt = l; sr = (mode == 3) && (w == 3 * t);
    end else begin
      cnt = l - (w - st * t) / PS;
    end
    return {(st >= 1), (st >= 2), sr, 6'(cnt)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {29'd0, |irq, |nmi, |srst}, 32'd0);
    for (int k = 0; k < NC; k++) begin
      rd_core = CW'(k);
      #1;
      chk("R1 count", 32'(rd_cnt), 32'd0);
    end

    // R4 R5 R6 R7 R10 vector table
    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      int c, len, mode, w;
      logic [NC-1:0] others;
      v = VEC[i];
      c = int'(v[15:14]); len = int'(v[13:10]); mode = int'(v[9:8]); w = int'(v[7:0]);
      clear_all();
      rd_core = CW'(c);
      write_cfg(c, len, mode);
      do_poke(c);
      repeat (w) @(negedge clk);
      others = (irq | nmi | srst) & ~(NC'(1) << c);
      chk($sformatf("R4 R5 R6 R7 R10 vector %0d", i),
          {22'd0, |others, irq[c], nmi[c], srst[c], rd_cnt},
          {22'd0, 1'b0, model(len, mode, w)});
    end

    // R2 config load and readback
    clear_all();
    rd_core = 2'd0;
    write_cfg(0, 5, 0);
    chk("R2 reload", 32'(rd_cnt), 32'd20);

    // R3 prescaler cleared on poke, one decrement per interval
    write_cfg(0, 1, 3);
    do_poke(0);
    @(negedge clk);
    chk("R3 first interval", 32'(rd_cnt), 32'd4);
    @(negedge clk);
    chk("R3 first tick", 32'(rd_cnt), 32'd3);

    // R5 then R8
    repeat (23) @(negedge clk);
    chk("R5 irq+nmi levels", {30'd0, irq[0], nmi[0]}, 32'd3);
    do_poke(0);
    chk("R8 poke clears", {24'd0, irq[0], nmi[0], rd_cnt}, 32'd4);

    // R9 all-zero config disables
    repeat (15) @(negedge clk);
    chk("R5 irq level", {31'd0, irq[0]}, 32'd1);
    write_cfg(0, 0, 0);
    chk("R9 disable", {23'd0, irq[0], nmi[0], srst[0], rd_cnt}, 32'd0);
    do_poke(0);
    repeat (40) @(negedge clk);
    chk("R9 stays off", {23'd0, irq[0], nmi[0], srst[0], rd_cnt}, 32'd0);

    // R10 pokes isolated per core
    clear_all();
    write_cfg(0, 1, 3);
    write_cfg(1, 1, 3);
    do_poke(0);
    do_poke(1);
    for (int j = 0; j < 3; j++) begin
      repeat (3) @(negedge clk);
      do_poke(1);
    end
    chk("R10 isolation", {29'd0, irq}, 32'd1);

    // R11 config and poke together
    clear_all();
    rd_core = 2'd0;
    write_cfg(0, 1, 3);
    cfg_we = 1'b1; cfg_core = 2'd0; cfg_len = 4'd2; cfg_mode = 2'd3; poke = 3'b001;
    @(negedge clk);
    cfg_we = 1'b0; poke = '0;
    chk("R11 new length", 32'(rd_cnt), 32'd8);
    repeat (17) @(negedge clk);
    chk("R11 no early irq", {31'd0, irq[0]}, 32'd0);
    @(negedge clk);
    chk("R11 irq at new period", {31'd0, irq[0]}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule